// File: doc/BRIEF.md
# CAN Receive Slot Acceptance Filter

This block sits behind a CAN receiver and decides which of sixteen message slots should take a frame that has just arrived. It is given the frame's 29-bit identifier and a flag that says whether the frame used the 11-bit standard or the 29-bit extended format. Every slot holds an identifier, a format bit, a direction bit (transmit or receive) and an enable bit. A slot is checked through the mask that belongs to its index. Slots 0 to 13 share one common mask. Slot 14 and slot 15 each have a private mask, so either one can be opened up as a catch-all receive buffer. When several slots match, the lowest-numbered slot wins.

The same lowest-index rule picks the next frame to send. From the slots set up as transmitters that also have a pending request bit, the lowest-numbered one is chosen. Software fills in every setting through a plain write port. Filtering itself is combinational. A small two-state sequencer registers the verdict, so the result shows up one clock after the identifier strobe, together with a valid pulse.

The sequencer has two states. ST_IDLE is the state when no result is on offer. ST_RESULT holds for one cycle and presents the registered verdict. Transition T_CAPTURE goes from either state to ST_RESULT when `rx_valid` is sampled high. Transition T_RELEASE goes from either state to ST_IDLE when `rx_valid` is sampled low.

Top module: `can_slot_filter`

## Requirements
- R1: After reset, `res_valid`, `res_hit`, `res_match`, `res_slot`, `tx_valid` and `tx_slot` are all zero. All slot settings, all masks and all transmit requests are cleared.
- R2: `res_valid` is high in exactly the cycle that follows each clock edge where `rx_valid` was sampled high. Strobes on back-to-back cycles each produce their own result, in order.
- R3: A mask bit of 1 requires the received identifier bit to equal the slot's identifier bit. A mask bit of 0 makes that bit a don't-care.
- R4: Slots 0 to 13 use the common mask, written at address 16. Slot 14 uses private mask A at address 17, and slot 15 uses private mask B at address 18. A mask has no effect on any slot it does not belong to.
- R5: A frame can hit a slot only when `rx_ext` equals the slot's format bit. For standard frames (`rx_ext`=0), only `rx_id[28:18]` is compared and `rx_id[17:0]` is ignored.
- R6: Only slots whose enable bit is 1 and whose direction bit is 0 (receive) can be hit. Slots that are disabled or set to transmit never appear in the result.
- R7: When several slots match, `res_slot` gives the lowest-numbered one. `res_match` is one-hot at that slot.
- R8: When no slot matches, `res_hit` is 0, `res_slot` is 0 and `res_match` is all zeros.
- R9: `tx_slot` gives the lowest-numbered slot that has direction bit 1 and request bit set, and `tx_valid` is then 1. If no such slot exists, both are 0. The outputs follow the settings with a one-cycle register delay.
- R10: The write port map is as follows. Addresses 0 to 15 hold the slot words: bit 31 is enable, bit 30 is direction (1 = transmit), bit 29 is format (1 = extended) and bits 28:0 are the identifier. Addresses 16, 17 and 18 hold the masks in bits 28:0. Address 19 holds the transmit request bits in bits 15:0, one bit per slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write enable for the settings port |
| cfg_addr | input | 5 | Settings address |
| cfg_wdata | input | 32 | Settings write data |
| rx_valid | input | 1 | Strobe that marks a received identifier |
| rx_id | input | 29 | Received identifier; standard frames use bits 28:18 |
| rx_ext | input | 1 | Frame format: 1 = extended, 0 = standard |
| res_valid | output | 1 | Result valid, one cycle after the strobe |
| res_match | output | 16 | One-hot vector of the winning slot |
| res_slot | output | 4 | Index of the winning slot |
| res_hit | output | 1 | At least one slot matched |
| tx_valid | output | 1 | A transmit slot is pending |
| tx_slot | output | 4 | Index of the lowest pending transmit slot |

## Verification
The hardest case to reach from the ports is a frame that matches several slots for different reasons at once. One example is a receive slot and a transmit slot with the same identifier. Another is a disabled slot with a lower index than the real winner. A third is a slot whose match depends on a private mask while its neighbours use the common mask. The stimulus builds these cases step by step. It writes overlapping identifiers into slots 0, 1, 2 and 5. It then widens the common mask so that several of them match the same frame. Finally it rewrites private masks A and B between frames, to show that each mask changes only its own slot's verdict.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
    localparam int ID_W  = 29;
    localparam int STD_W = 11;

    typedef struct packed {
        logic            rx_en;
        logic            is_tx;
        logic            ext;
        logic [ID_W-1:0] id;
    } slot_cfg_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } res_state_t;
endpackage

// File: rtl/filt_cfg_regs.sv
module filt_cfg_regs
    import can_filt_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int ADDR_W    = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [31:0]                  wdata,
    output slot_cfg_t [NUM_SLOTS-1:0]    slot_cfg,
    output logic [ID_W-1:0]              mask_g,
    output logic [ID_W-1:0]              mask_a,
    output logic [ID_W-1:0]              mask_b,
    output logic [NUM_SLOTS-1:0]         tx_req
);
    localparam int A_MASK_G = NUM_SLOTS;
    localparam int A_MASK_A = NUM_SLOTS + 1;
    localparam int A_MASK_B = NUM_SLOTS + 2;
    localparam int A_TXREQ  = NUM_SLOTS + 3;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_cfg[s] <= '0;
            else if (we && addr == ADDR_W'(s))
                slot_cfg[s] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_g <= '0;
            mask_a <= '0;
            mask_b <= '0;
            tx_req <= '0;
        end else if (we) begin
            if (addr == ADDR_W'(A_MASK_G)) mask_g <= wdata[ID_W-1:0];
            if (addr == ADDR_W'(A_MASK_A)) mask_a <= wdata[ID_W-1:0];
            if (addr == ADDR_W'(A_MASK_B)) mask_b <= wdata[ID_W-1:0];
            if (addr == ADDR_W'(A_TXREQ))  tx_req <= wdata[NUM_SLOTS-1:0];
        end
    end
endmodule

// File: rtl/filt_slot_match.sv
module filt_slot_match
    import can_filt_pkg::*;
#(
    parameter int NUM_SLOTS = 16
) (
    input  slot_cfg_t [NUM_SLOTS-1:0] slot_cfg,
    input  logic [ID_W-1:0]           mask_g,
    input  logic [ID_W-1:0]           mask_a,
    input  logic [ID_W-1:0]           mask_b,
    input  logic [ID_W-1:0]           rx_id,
    input  logic                      rx_ext,
    output logic [NUM_SLOTS-1:0]      hit
);
    localparam logic [ID_W-1:0] STD_KEEP = {{STD_W{1'b1}}, {(ID_W-STD_W){1'b0}}};

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
        logic [ID_W-1:0] mask_sel;
        logic [ID_W-1:0] mask_eff;
        if (s == NUM_SLOTS - 1) begin : g_mb
            assign mask_sel = mask_b;
        end else if (s == NUM_SLOTS - 2) begin : g_ma
            assign mask_sel = mask_a;
        end else begin : g_mg
            assign mask_sel = mask_g;
        end
        assign mask_eff = rx_ext ? mask_sel : (mask_sel & STD_KEEP);
        assign hit[s] = slot_cfg[s].rx_en & ~slot_cfg[s].is_tx
                      & (slot_cfg[s].ext == rx_ext)
                      & ~|((rx_id ^ slot_cfg[s].id) & mask_eff);
    end
endmodule

// File: rtl/filt_prio_pick.sv
module filt_prio_pick #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     onehot,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        onehot = '0;
        idx    = '0;
        any    = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                onehot    = '0;
                onehot[i] = 1'b1;
                idx       = IDX_W'(i);
                any       = 1'b1;
            end
        end
    end
endmodule

// File: rtl/can_slot_filter.sv
module can_slot_filter
    import can_filt_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int ADDR_W    = $clog2(NUM_SLOTS + 4),
    parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [31:0]          cfg_wdata,
    input  logic                 rx_valid,
    input  logic [ID_W-1:0]      rx_id,
    input  logic                 rx_ext,
    output logic                 res_valid,
    output logic [NUM_SLOTS-1:0] res_match,
    output logic [IDX_W-1:0]     res_slot,
    output logic                 res_hit,
    output logic                 tx_valid,
    output logic [IDX_W-1:0]     tx_slot
);
    slot_cfg_t [NUM_SLOTS-1:0] slot_cfg;
    logic [ID_W-1:0]           mask_g, mask_a, mask_b;
    logic [NUM_SLOTS-1:0]      tx_req;
    logic [NUM_SLOTS-1:0]      rx_hit_vec;
    logic [NUM_SLOTS-1:0]      rx_onehot;
    logic [IDX_W-1:0]          rx_idx;
    logic                      rx_any;
    logic [NUM_SLOTS-1:0]      tx_cand;
    logic [NUM_SLOTS-1:0]      tx_onehot;
    logic [IDX_W-1:0]          tx_idx;
    logic                      tx_any;
    res_state_t                state, state_nx;

    filt_cfg_regs #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .slot_cfg(slot_cfg), .mask_g(mask_g), .mask_a(mask_a), .mask_b(mask_b),
        .tx_req(tx_req)
    );

    filt_slot_match #(.NUM_SLOTS(NUM_SLOTS)) u_match (
        .slot_cfg(slot_cfg), .mask_g(mask_g), .mask_a(mask_a), .mask_b(mask_b),
        .rx_id(rx_id), .rx_ext(rx_ext), .hit(rx_hit_vec)
    );

    filt_prio_pick #(.N(NUM_SLOTS), .IDX_W(IDX_W)) u_rx_pick (
        .req(rx_hit_vec), .onehot(rx_onehot), .idx(rx_idx), .any(rx_any)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_txc
        assign tx_cand[s] = slot_cfg[s].is_tx & tx_req[s];
    end

    filt_prio_pick #(.N(NUM_SLOTS), .IDX_W(IDX_W)) u_tx_pick (
        .req(tx_cand), .onehot(tx_onehot), .idx(tx_idx), .any(tx_any)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions: T_CAPTURE on strobe, T_RELEASE otherwise
    always_comb begin
        state_nx = ST_IDLE;
        unique case (state)
            ST_IDLE:   state_nx = rx_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_nx = rx_valid ? ST_RESULT : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb res_valid = (state == ST_RESULT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_match <= '0;
            res_slot  <= '0;
            res_hit   <= 1'b0;
            tx_valid  <= 1'b0;
            tx_slot   <= '0;
        end else begin
            if (rx_valid) begin
                res_match <= rx_onehot;
                res_slot  <= rx_idx;
                res_hit   <= rx_any;
            end
            tx_valid <= tx_any;
            tx_slot  <= tx_idx;
            if (tx_onehot == '0) tx_slot <= '0;
        end
    end
endmodule

// File: rtl/can_slot_filter_chk.sv
module can_slot_filter_chk #(
    parameter int NUM_SLOTS = 16,
    parameter int IDX_W     = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_valid,
    input logic                 res_valid,
    input logic [NUM_SLOTS-1:0] res_match,
    input logic [IDX_W-1:0]     res_slot,
    input logic                 res_hit,
    input logic                 tx_valid,
    input logic [IDX_W-1:0]     tx_slot
);
    assert_strobe_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> res_valid);
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !res_valid);
    assert_match_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(res_match));
    assert_slot_agrees_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_match[res_slot]);
    assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> (res_slot == '0 && res_match == '0));
    assert_tx_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid |-> tx_slot == '0);
endmodule

bind can_slot_filter can_slot_filter_chk #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .res_valid(res_valid),
    .res_match(res_match), .res_slot(res_slot), .res_hit(res_hit),
    .tx_valid(tx_valid), .tx_slot(tx_slot)
);

// File: tb/can_slot_filter_tb.sv
`timescale 1ns/1ps
module can_slot_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        rx_valid = 1'b0;
    logic [28:0] rx_id = '0;
    logic        rx_ext = 1'b0;
    logic        res_valid;
    logic [15:0] res_match;
    logic [3:0]  res_slot;
    logic        res_hit;
    logic        tx_valid;
    logic [3:0]  tx_slot;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct { bit hit; logic [3:0] slot; string tag; } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    can_slot_filter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_id(rx_id), .rx_ext(rx_ext),
        .res_valid(res_valid), .res_match(res_match), .res_slot(res_slot),
        .res_hit(res_hit), .tx_valid(tx_valid), .tx_slot(tx_slot)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] slot_word(bit en, bit tx, bit ext, logic [28:0] id);
        return {en, tx, ext, id};
    endfunction

    // driver: pushes the expectation, then holds the strobe for one edge
    task automatic send(input logic [28:0] id, input bit ext, input bit hit,
                        input logic [3:0] slot, input string tag);
        exp_t e;
        @(negedge clk);
        e.hit = hit; e.slot = slot; e.tag = tag;
        q.push_back(e);
        rx_valid = 1'b1; rx_id = id; rx_ext = ext;
    endtask

    task automatic idle();
        @(negedge clk);
        rx_valid = 1'b0;
        @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (q.size() == 0) begin
                chk(1'b0, "R2 result without strobe", 1, 0);
            end else begin
                exp_t e;
                logic [15:0] m;
                e = q.pop_front();
                m = e.hit ? (16'h1 << e.slot) : 16'h0;
                chk(res_hit == e.hit, {e.tag, " hit"}, res_hit, e.hit);
                chk(res_slot == e.slot, {e.tag, " slot"}, res_slot, e.slot);
                chk(res_match == m, {e.tag, " match"}, res_match, m);
            end
        end
    end

    task automatic tx_check(input bit v, input logic [3:0] s, input string tag);
        repeat (3) @(negedge clk);
        chk(tx_valid == v, {tag, " tx_valid"}, tx_valid, v);
        chk(tx_slot == s, {tag, " tx_slot"}, tx_slot, s);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!res_valid && !res_hit && res_match == 0 && res_slot == 0, "R1 rx outputs",
            {res_valid, res_hit, res_match, res_slot}, 0);
        chk(!tx_valid && tx_slot == 0, "R1 tx outputs", {tx_valid, tx_slot}, 0);

        // R10 map: common mask full, slot 3 standard, slot 5 extended
        wr(5'd16, 32'h1FFF_FFFF);
        wr(5'd3, slot_word(1, 0, 0, {11'h123, 18'h0}));
        wr(5'd5, slot_word(1, 0, 1, 29'h0ABC_DEF1));

        send({11'h123, 18'h3ABC}, 1'b0, 1, 4'd3, "R5 std low bits ignored"); idle();
        send({11'h123, 18'h0}, 1'b1, 0, 4'd0, "R5 format mismatch / R8"); idle();
        send(29'h0ABC_DEF1, 1'b1, 1, 4'd5, "R3 exact ext"); idle();
        send(29'h0ABC_DEF0, 1'b1, 0, 4'd0, "R3 masked bit differs"); idle();

        wr(5'd16, 32'h1FFF_FFF0);
        send(29'h0ABC_DEF0, 1'b1, 1, 4'd5, "R3 dont-care bits"); idle();

        // priority and eligibility
        wr(5'd2, slot_word(1, 0, 1, 29'h0ABC_DEF7));
        send(29'h0ABC_DEF4, 1'b1, 1, 4'd2, "R7 lowest wins"); idle();
        wr(5'd1, slot_word(1, 1, 1, 29'h0ABC_DEF4));
        wr(5'd0, slot_word(0, 0, 1, 29'h0ABC_DEF4));
        send(29'h0ABC_DEF4, 1'b1, 1, 4'd2, "R6 tx and disabled skipped"); idle();

        // private masks
        wr(5'd14, slot_word(1, 0, 1, 29'h0));
        wr(5'd15, slot_word(1, 0, 0, {11'h7FF, 18'h0}));
        wr(5'd18, 32'h1FFF_FFFF);
        send(29'h1234_5678, 1'b1, 1, 4'd14, "R4 mask A open"); idle();
        send({11'h7FF, 18'h1}, 1'b0, 1, 4'd15, "R4 slot15 exact"); idle();
        send({11'h7FE, 18'h0}, 1'b0, 0, 4'd0, "R4 mask B full misses"); idle();
        wr(5'd18, 32'h0);
        send({11'h7FE, 18'h0}, 1'b0, 1, 4'd15, "R4 mask B open"); idle();
        wr(5'd17, 32'h1FFF_FFFF);
        send(29'h1234_5678, 1'b1, 0, 4'd0, "R4 mask A full misses"); idle();

        // back-to-back strobes
        send(29'h0ABC_DEF1, 1'b1, 1, 4'd2, "R2 first of pair");
        send({11'h123, 18'h0}, 1'b0, 1, 4'd3, "R2 second of pair");
        idle();

        // transmit selection
        wr(5'd7, slot_word(1, 1, 0, {11'h055, 18'h0}));
        wr(5'd19, 32'h0000_0082);
        tx_check(1, 4'd1, "R9 lowest tx");
        wr(5'd19, 32'h0000_0080);
        tx_check(1, 4'd7, "R9 single tx");
        wr(5'd19, 32'h0000_0004);
        tx_check(0, 4'd0, "R9 request on rx slot");

        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R2 all results seen", q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule